// File: doc/BRIEF.md
# Torus Dimension-Order Route Unit

This unit computes the next hop for a head flit travelling through a two-dimensional torus, where both dimensions have wrap-around links. It is given the coordinates of the node it sits in, the coordinates of the packet's destination, the dimension the flit arrived on, and the virtual channel the flit arrived on. From these it returns one output port and one output virtual channel.

The route is deterministic and minimal. All X travel finishes before any Y travel starts. In each dimension the packet takes the shorter way around the ring.

Deadlock is avoided with two virtual channels and a dateline on each ring. The dateline is the link between the highest coordinate and coordinate zero, in both directions. A packet runs on channel 0 until a hop crosses the dateline of its current dimension. From then on it stays on channel 1 until it leaves that dimension. When the packet enters a new dimension, it starts again on channel 0.

The decision logic is combinational and is followed by one output register stage. The router's input stage presents a head flit with `in_valid`. The switch allocator reads the decision one clock later.

Top module: `tor_dor_route`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0, `out_port` is 0 (local) and `out_vc` is 0.
- R2: Every output is registered. `out_valid`, `out_port` and `out_vc` show the inputs sampled at the previous rising clock edge, and `out_valid` equals the `in_valid` sampled at that edge.
- R3: While `cur_x` differs from `dst_x`, the port is +X (code 1) or -X (code 2), whatever the Y offset. A Y port (+Y code 3, -Y code 4) is only given when `cur_x` equals `dst_x`.
- R4: For each dimension with ring size N, let d = (dst - cur) mod N. The direction is positive when 2·d ≤ N and negative otherwise. An exact half-ring offset therefore goes positive.
- R5: When both coordinates equal the destination, the port is local (code 0) and the channel is 0.
- R6: A hop that crosses the dateline gets channel 1. The dateline hops are: +X from x = NX-1, -X from x = 0, +Y from y = NY-1, and -Y from y = 0.
- R7: When the flit arrived on the same dimension it now leaves on (`in_dim` 1 for X, 2 for Y) and `in_vc` is 1, `out_vc` is 1.
- R8: When the flit enters a dimension it did not arrive on (injection is `in_dim` 0 or 3, or a turn from X into Y), `out_vc` is 0 unless that hop crosses the dateline. The same holds when the flit stays in its dimension on channel 0.
- R9: The result depends only on the current inputs. The same inputs always give the same port and channel, whatever was routed before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the output stage |
| in_valid | input | 1 | A head flit is presented for routing |
| cur_x | input | $clog2(NX) | X coordinate of this node |
| cur_y | input | $clog2(NY) | Y coordinate of this node |
| dst_x | input | $clog2(NX) | Destination X coordinate |
| dst_y | input | $clog2(NY) | Destination Y coordinate |
| in_dim | input | 2 | Arrival dimension: 0 or 3 injection, 1 X, 2 Y |
| in_vc | input | 1 | Virtual channel of arrival |
| out_valid | output | 1 | Registered routing decision is valid |
| out_port | output | 3 | 0 local, 1 +X, 2 -X, 3 +Y, 4 -Y |
| out_vc | output | 1 | Virtual channel for the output link |

## Verification
The bench sweeps every combination of node, destination, arrival dimension and arrival channel on a 4-by-6 torus. This covers one ring whose size is a power of two and one whose size is not.

The half-ring tie is a key corner. A design that resolved it towards the negative direction would send offset 2 on the 4-ring, or offset 3 on the 6-ring, the wrong way.

Wrap cases are another target. A ring-size variant that forgot the modulo correction would go the long way around the 6-ring.

The sweep also covers the channel rules:
- A misplaced dateline would show up as channel 1 at the wrong coordinate.
- A channel that failed to reset on the turn from X into Y would carry channel 1 into the Y ring.
- A channel that failed to stick would fall back to 0 after a crossing.

Finally, the bench drives coordinate pairs that differ in both dimensions. A design that moved in Y first would be caught there.

// File: rtl/torus_rt_pkg.sv
package torus_rt_pkg;

   typedef enum logic [2:0] {
      PORT_LOCAL = 3'd0,
      PORT_XP    = 3'd1,
      PORT_XN    = 3'd2,
      PORT_YP    = 3'd3,
      PORT_YN    = 3'd4
   } port_e;

   typedef enum logic [1:0] {
      DIM_INJ  = 2'd0,
      DIM_X    = 2'd1,
      DIM_Y    = 2'd2,
      DIM_INJ2 = 2'd3
   } dim_e;

   localparam int VC_LOW  = 0;
   localparam int VC_HIGH = 1;

endpackage

// File: rtl/tor_ring_dir.sv
module tor_ring_dir #(
   parameter int N = 8,
   localparam int W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [W-1:0] cur,
   input  logic [W-1:0] dst,
   output logic         move,
   output logic         pos,
   output logic         wrap
);

   localparam bit           POW2   = (N == (1 << W));
   localparam logic [W+1:0] N_EXT  = (W+2)'(N);
   localparam logic [W-1:0] C_LAST = W'(N - 1);
   localparam logic [W-1:0] C_ZERO = '0;

   logic [W:0] diff;

   generate
      if (N < 2) begin : g_bad_size
         $error("tor_ring_dir: ring size must be at least 2");
      end

      if (POW2) begin : g_pow2
         logic [W-1:0] d_trunc;
         always_comb begin
            d_trunc = dst - cur;
            diff    = {1'b0, d_trunc};
         end
      end else begin : g_general
         always_comb begin
            if (dst >= cur) diff = {1'b0, dst} - {1'b0, cur};
            else            diff = {1'b0, dst} + (W+1)'(N) - {1'b0, cur};
         end
      end
   endgenerate

   always_comb begin
      move = (diff != '0);
      pos  = ({diff, 1'b0} <= N_EXT);
      if (!move)    wrap = 1'b0;
      else if (pos) wrap = (cur == C_LAST);
      else          wrap = (cur == C_ZERO);
   end

endmodule

// File: rtl/tor_dor_select.sv
module tor_dor_select
   import torus_rt_pkg::*;
(
   input  logic       x_move,
   input  logic       x_pos,
   input  logic       x_wrap,
   input  logic       y_move,
   input  logic       y_pos,
   input  logic       y_wrap,
   input  logic [1:0] in_dim,
   input  logic       in_vc,
   output port_e      port,
   output logic       vc
);

   logic stay_x;
   logic stay_y;

   always_comb begin
      stay_x = (in_dim == DIM_X) && in_vc;
      stay_y = (in_dim == DIM_Y) && in_vc;
   end

   always_comb begin
      if (x_move) begin
         port = x_pos ? PORT_XP : PORT_XN;
         vc   = stay_x | x_wrap;
      end else if (y_move) begin
         port = y_pos ? PORT_YP : PORT_YN;
         vc   = stay_y | y_wrap;
      end else begin
         port = PORT_LOCAL;
         vc   = 1'b0;
      end
   end

endmodule

// File: rtl/tor_dor_route.sv
module tor_dor_route
   import torus_rt_pkg::*;
#(
   parameter int NX = 8,
   parameter int NY = 8,
   localparam int XW = (NX > 1) ? $clog2(NX) : 1,
   localparam int YW = (NY > 1) ? $clog2(NY) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [XW-1:0] cur_x,
   input  logic [YW-1:0] cur_y,
   input  logic [XW-1:0] dst_x,
   input  logic [YW-1:0] dst_y,
   input  logic [1:0]    in_dim,
   input  logic          in_vc,
   output logic          out_valid,
   output logic [2:0]    out_port,
   output logic          out_vc
);

   localparam logic [XW-1:0] X_LAST = XW'(NX - 1);
   localparam logic [YW-1:0] Y_LAST = YW'(NY - 1);

   generate
      if (NX < 2 || NY < 2) begin : g_bad_dims
         $error("tor_dor_route: each torus dimension needs at least 2 nodes");
      end
   endgenerate

   logic  x_move, x_pos, x_wrap;
   logic  y_move, y_pos, y_wrap;
   port_e nxt_port;
   logic  nxt_vc;

   tor_ring_dir #(.N(NX)) u_ring_x (
      .cur  (cur_x),
      .dst  (dst_x),
      .move (x_move),
      .pos  (x_pos),
      .wrap (x_wrap)
   );

   tor_ring_dir #(.N(NY)) u_ring_y (
      .cur  (cur_y),
      .dst  (dst_y),
      .move (y_move),
      .pos  (y_pos),
      .wrap (y_wrap)
   );

   tor_dor_select u_sel (
      .x_move (x_move),
      .x_pos  (x_pos),
      .x_wrap (x_wrap),
      .y_move (y_move),
      .y_pos  (y_pos),
      .y_wrap (y_wrap),
      .in_dim (in_dim),
      .in_vc  (in_vc),
      .port   (nxt_port),
      .vc     (nxt_vc)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_port  <= PORT_LOCAL;
         out_vc    <= 1'b0;
      end else begin
         out_valid <= in_valid;
         out_port  <= nxt_port;
         out_vc    <= nxt_vc;
      end
   end

   p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   p_valid_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   p_x_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && (out_port == PORT_YP || out_port == PORT_YN))
         |-> ($past(cur_x) == $past(dst_x)));

   p_eject_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(cur_x) == $past(dst_x) && $past(cur_y) == $past(dst_y))
         |-> (out_port == PORT_LOCAL && !out_vc));

   p_dateline_x_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && ((out_port == PORT_XP && $past(cur_x) == X_LAST) ||
                     (out_port == PORT_XN && $past(cur_x) == '0)))
         |-> out_vc);

   p_dateline_y_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && ((out_port == PORT_YP && $past(cur_y) == Y_LAST) ||
                     (out_port == PORT_YN && $past(cur_y) == '0)))
         |-> out_vc);

   p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(in_vc) &&
       (((out_port == PORT_XP || out_port == PORT_XN) && $past(in_dim) == DIM_X) ||
        ((out_port == PORT_YP || out_port == PORT_YN) && $past(in_dim) == DIM_Y)))
         |-> out_vc);

   p_turn_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(in_dim) == DIM_X &&
       ((out_port == PORT_YP && $past(cur_y) != Y_LAST) ||
        (out_port == PORT_YN && $past(cur_y) != '0)))
         |-> !out_vc);

endmodule

// File: tb/tor_dor_route_tb.sv
module tor_dor_route_tb;

   localparam int NX = 4;
   localparam int NY = 6;
   localparam int XW = $clog2(NX);
   localparam int YW = $clog2(NY);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [XW-1:0] cur_x = '0;
   logic [YW-1:0] cur_y = '0;
   logic [XW-1:0] dst_x = '0;
   logic [YW-1:0] dst_y = '0;
   logic [1:0]    in_dim = '0;
   logic          in_vc = 1'b0;
   logic          out_valid;
   logic [2:0]    out_port;
   logic          out_vc;

   int n_cmp  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   tor_dor_route #(.NX(NX), .NY(NY)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .cur_x     (cur_x),
      .cur_y     (cur_y),
      .dst_x     (dst_x),
      .dst_y     (dst_y),
      .in_dim    (in_dim),
      .in_vc     (in_vc),
      .out_valid (out_valid),
      .out_port  (out_port),
      .out_vc    (out_vc)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d (cur=%0d,%0d dst=%0d,%0d dim=%0d vc=%0d)",
                  tag, act, exp, cur_x, cur_y, dst_x, dst_y, in_dim, in_vc);
      end
   endtask

   // Reference model built from the requirements
   task automatic model(input int cx, input int cy, input int dx, input int dy,
                        input int dim, input int vc,
                        output int port, output int ovc,
                        output string tport, output string tvc);
      int ox, oy;
      bit pos, wrap, stay;
      ox = (dx - cx + NX) % NX;
      oy = (dy - cy + NY) % NY;
      if (ox != 0) begin
         pos   = (2 * ox <= NX);
         port  = pos ? 1 : 2;
         wrap  = pos ? (cx == NX - 1) : (cx == 0);
         stay  = (dim == 1) && (vc == 1);
         ovc   = (stay || wrap) ? 1 : 0;
         tport = (oy != 0) ? "R3 x-first port" : "R4 x direction";
      end else if (oy != 0) begin
         pos   = (2 * oy <= NY);
         port  = pos ? 3 : 4;
         wrap  = pos ? (cy == NY - 1) : (cy == 0);
         stay  = (dim == 2) && (vc == 1);
         ovc   = (stay || wrap) ? 1 : 0;
         tport = "R4 y direction";
      end else begin
         port  = 0;
         ovc   = 0;
         wrap  = 1'b0;
         stay  = 1'b0;
         tport = "R5 eject port";
      end
      if (port == 0)  tvc = "R5 eject vc";
      else if (wrap)  tvc = "R6 dateline vc";
      else if (stay)  tvc = "R7 sticky vc";
      else            tvc = "R8 reset vc";
   endtask

   task automatic drive(input int cx, input int cy, input int dx, input int dy,
                        input int dim, input int vc);
      cur_x  = XW'(cx);
      cur_y  = YW'(cy);
      dst_x  = XW'(dx);
      dst_y  = YW'(dy);
      in_dim = 2'(dim);
      in_vc  = 1'(vc);
   endtask

   initial begin
      int ep, ev, p1, v1;
      string tp, tv;
      // R1: reset state while inputs are active
      in_valid = 1'b1;
      drive(0, 0, 3, 5, 1, 1);
      repeat (3) @(negedge clk);
      check("R1 out_valid in reset", out_valid, 0);
      check("R1 out_port in reset", out_port, 0);
      check("R1 out_vc in reset", out_vc, 0);
      rst_n = 1'b1;

      // Exhaustive sweep, one vector per clock
      for (int cx = 0; cx < NX; cx++)
         for (int cy = 0; cy < NY; cy++)
            for (int dx = 0; dx < NX; dx++)
               for (int dy = 0; dy < NY; dy++)
                  for (int dim = 0; dim < 4; dim++)
                     for (int vc = 0; vc < 2; vc++) begin
                        drive(cx, cy, dx, dy, dim, vc);
                        in_valid = 1'b1;
                        @(negedge clk);
                        model(cx, cy, dx, dy, dim, vc, ep, ev, tp, tv);
                        check("R2 out_valid", out_valid, 1);
                        check(tp, out_port, ep);
                        check(tv, out_vc, ev);
                     end

      // R2: idle input gives idle output one cycle later
      in_valid = 1'b0;
      @(negedge clk);
      check("R2 out_valid idle", out_valid, 0);

      // R9: same inputs after different history give the same result
      in_valid = 1'b1;
      drive(3, 5, 1, 2, 1, 1);
      @(negedge clk);
      p1 = out_port;
      v1 = out_vc;
      drive(0, 0, 2, 3, 0, 0);
      @(negedge clk);
      drive(3, 5, 1, 2, 1, 1);
      @(negedge clk);
      model(3, 5, 1, 2, 1, 1, ep, ev, tp, tv);
      check("R9 repeat port", out_port, p1);
      check("R9 repeat vc", out_vc, v1);
      check("R9 port vs model", out_port, ep);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_cmp++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
         $finish;
      end
   end

endmodule